// File: doc/BRIEF.md
# Packed Integer Add/Subtract/Compare Unit

This block is a two-stage pipelined arithmetic unit that treats a 64-bit operand pair as a set of independent lanes. The element-size select splits each operand into eight bytes, four words or two doublewords. Each lane performs one of three operations: an add, a subtract (destination lane minus source lane), or an equality compare that produces a lane mask. No carry or borrow ever passes from one lane into the next.

Add and subtract results follow one of three policies: plain modular wrap, clamping to the signed range of the lane, or clamping to the unsigned range of the lane. Clamping is only defined for byte and word lanes. If a clamping policy is requested on doubleword lanes, or if any reserved encoding is used, the unit raises an illegal-operation flag next to the result. A new operation may be presented on every cycle. Each result leaves the pipeline two cycles after it entered, and its operation code and size are carried along with the data.

Top module: `simd_addsub_unit`

## Requirements
- R1: Add (op=00) with wrap policy (mode=00) returns, for each lane, the low lane-width bits of dst+src. The lane width is 8 for size=00, 16 for size=01 and 32 for size=10, and no carry passes into the neighbouring lane.
- R2: Subtract (op=01) with wrap policy returns, for each lane, the low lane-width bits of dst−src, and no borrow passes into the neighbouring lane.
- R3: With signed clamping (mode=01) on byte or word lanes, a lane whose true signed add/subtract result is above the signed maximum returns 7Fh or 7FFFh, and one below the signed minimum returns 80h or 8000h.
- R4: With unsigned clamping (mode=10), an add lane whose true sum exceeds the lane range returns all ones (FFh or FFFFh).
- R5: With unsigned clamping, a subtract lane whose true difference is negative returns zero.
- R6: Compare (op=10) returns all ones in each lane whose two elements are equal and all zeros otherwise, for every size. The mode field is ignored and the illegal flag stays low.
- R7: An operation accepted while in_valid is high in cycle t appears with res_valid high in cycle t+2. Operations may be accepted in consecutive cycles, and res_valid is low in cycles that correspond to idle inputs.
- R8: While rst_n is low, every in-flight operation is discarded. Starting with the cycle after the first reset edge, res_valid reads 0 until new operations arrive.
- R9: A clamping mode (01 or 10) on doubleword lanes (size=10) for add or subtract sets res_illegal and returns the wrap result.
- R10: Reserved encodings set res_illegal. Op 11 and size 11 return an all-zero result. Mode 11 on add or subtract returns the wrap result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| dst | input | 64 | Destination (first) operand, packed lanes |
| src | input | 64 | Source (second) operand, packed lanes |
| op | input | 2 | 00 add, 01 subtract, 10 compare equal, 11 reserved |
| mode | input | 2 | 00 wrap, 01 signed clamp, 10 unsigned clamp, 11 reserved |
| size | input | 2 | 00 byte, 01 word, 10 doubleword, 11 reserved |
| res_valid | output | 1 | Result present this cycle |
| res | output | 64 | Packed result |
| res_illegal | output | 1 | Result came from an illegal or reserved request |

## Verification
The hardest condition to reach is isolation at the lane boundaries. A carry or borrow that leaks into a neighbouring lane only becomes visible when one lane overflows while the lane above it is sensitive to a single extra unit, and that must happen under every policy at once. The stimulus covers this by sweeping every byte pair across the eight lanes with adjacent lanes offset from one another. Word and doubleword lanes receive sign-boundary corner values (7FFF/8000, FFFF/0000 and the 32-bit equivalents) in rotated positions, followed by pseudo-random operands. The bench also asserts reset while operations are still in flight, to confirm that they are dropped.

// File: rtl/simd_pkg.sv
// Shared encodings for the packed add/subtract unit.
// Assumes 2-bit fields for operation, result policy and lane size.
package simd_pkg;

    typedef enum logic [1:0] {
        OP_ADD   = 2'b00,
        OP_SUB   = 2'b01,
        OP_CMPEQ = 2'b10,
        OP_RSVD  = 2'b11
    } simd_op_e;

    typedef enum logic [1:0] {
        POL_WRAP = 2'b00,
        POL_SSAT = 2'b01,
        POL_USAT = 2'b10,
        POL_RSVD = 2'b11
    } simd_pol_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_DWORD = 2'b10,
        SZ_RSVD  = 2'b11
    } simd_size_e;

    // True when a request must be flagged as illegal or reserved.
    function automatic logic req_illegal(simd_op_e o, simd_pol_e p, simd_size_e s);
        logic arith;
        arith = (o == OP_ADD) || (o == OP_SUB);
        return (o == OP_RSVD) || (s == SZ_RSVD) ||
               (arith && (p == POL_RSVD)) ||
               (arith && (s == SZ_DWORD) && (p != POL_WRAP));
    endfunction

endpackage

// File: rtl/simd_lane_op.sv
// One lane of the unit: add, subtract (a - b) or equality compare on a
// W-bit element. CLAMP_OK = 0 builds a lane that always wraps.
// Assumes the operation and policy are stable over the cycle (pure logic).
module simd_lane_op
    import simd_pkg::*;
#(
    parameter int W        = 8,
    parameter bit CLAMP_OK = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  simd_op_e     op,
    input  simd_pol_e    pol,
    output logic [W-1:0] r
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   wide;
    logic [W-1:0] low;
    logic         carry;
    logic         sovf;

    // Lane-local sum or difference with one extra bit for carry/borrow.
    always_comb begin
        if (op == OP_SUB) wide = {1'b0, a} - {1'b0, b};
        else              wide = {1'b0, a} + {1'b0, b};
        low   = wide[W-1:0];
        carry = wide[W];
    end

    // Signed overflow: result sign disagrees with the sign of a where
    // the operand signs allow an overflow at all.
    always_comb begin
        if (op == OP_SUB) sovf = (a[W-1] != b[W-1]) && (low[W-1] != a[W-1]);
        else              sovf = (a[W-1] == b[W-1]) && (low[W-1] != a[W-1]);
    end

    // Result selection by operation and policy.
    always_comb begin
        r = '0;
        case (op)
            OP_CMPEQ: r = (a == b) ? '1 : '0;
            OP_ADD, OP_SUB: begin
                r = low;
                if (CLAMP_OK && pol == POL_SSAT && sovf)
                    r = a[W-1] ? SMIN : SMAX;
                else if (CLAMP_OK && pol == POL_USAT && carry)
                    r = (op == OP_ADD) ? '1 : '0;
            end
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/simd_lane_array.sv
// Combinational lane array: builds byte, word and doubleword lane sets
// side by side and picks one by size. Doubleword lanes never clamp.
// Assumes DATA_W is a multiple of 32.
module simd_lane_array
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  simd_op_e          op,
    input  simd_pol_e         pol,
    input  simd_size_e        size,
    output logic [DATA_W-1:0] r,
    output logic              illegal
);
    localparam int NB = DATA_W / 8;
    localparam int NW = DATA_W / 16;
    localparam int ND = DATA_W / 32;

    logic [DATA_W-1:0] r_b, r_w, r_d;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        simd_lane_op #(.W(8), .CLAMP_OK(1'b1)) u_lane (
            .a(a[i*8 +: 8]), .b(b[i*8 +: 8]), .op(op), .pol(pol), .r(r_b[i*8 +: 8]));
    end

    for (genvar i = 0; i < NW; i++) begin : g_word
        simd_lane_op #(.W(16), .CLAMP_OK(1'b1)) u_lane (
            .a(a[i*16 +: 16]), .b(b[i*16 +: 16]), .op(op), .pol(pol), .r(r_w[i*16 +: 16]));
    end

    for (genvar i = 0; i < ND; i++) begin : g_dword
        simd_lane_op #(.W(32), .CLAMP_OK(1'b0)) u_lane (
            .a(a[i*32 +: 32]), .b(b[i*32 +: 32]), .op(op), .pol(pol), .r(r_d[i*32 +: 32]));
    end

    // Lane-set selection by element size; reserved size yields zero.
    always_comb begin
        case (size)
            SZ_BYTE:  r = r_b;
            SZ_WORD:  r = r_w;
            SZ_DWORD: r = r_d;
            default:  r = '0;
        endcase
    end

    // Flag illegal or reserved requests.
    always_comb illegal = req_illegal(op, pol, size);
endmodule

// File: rtl/simd_addsub_unit.sv
// Top: two-stage pipeline around the lane array. Stage 1 holds the
// operands and controls, stage 2 holds result and flag. One operation per
// cycle, result two cycles after acceptance. Synchronous active-low reset
// clears only the valid bits; data registers load only on valid.
module simd_addsub_unit
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    input  logic [1:0]        op,
    input  logic [1:0]        mode,
    input  logic [1:0]        size,
    output logic              res_valid,
    output logic [DATA_W-1:0] res,
    output logic              res_illegal
);
    logic              s1_valid;
    logic [DATA_W-1:0] s1_dst, s1_src;
    simd_op_e          s1_op;
    simd_pol_e         s1_pol;
    simd_size_e        s1_size;

    logic [DATA_W-1:0] lane_r;
    logic              lane_ill;

    // Stage 1 valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // Stage 1 operand and control capture.
    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_dst  <= dst;
            s1_src  <= src;
            s1_op   <= simd_op_e'(op);
            s1_pol  <= simd_pol_e'(mode);
            s1_size <= simd_size_e'(size);
        end
    end

    simd_lane_array #(.DATA_W(DATA_W)) u_lanes (
        .a(s1_dst), .b(s1_src), .op(s1_op), .pol(s1_pol), .size(s1_size),
        .r(lane_r), .illegal(lane_ill));

    // Stage 2 valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) res_valid <= 1'b0;
        else        res_valid <= s1_valid;
    end

    // Stage 2 result capture.
    always_ff @(posedge clk) begin
        if (s1_valid) begin
            res         <= lane_r;
            res_illegal <= lane_ill;
        end
    end
endmodule

// File: rtl/simd_addsub_chk.sv
// Checker for simd_addsub_unit, attached by bind. Properties look two
// cycles back only after two edges out of reset have passed.
module simd_addsub_chk
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] dst,
    input logic [1:0]        op,
    input logic [1:0]        mode,
    input logic [1:0]        size,
    input logic              res_valid,
    input logic [DATA_W-1:0] res,
    input logic              res_illegal
);
    localparam int NB = DATA_W / 8;

    logic [1:0] age;

    // Count edges since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= 2'd0;
        else if (age != 2) age <= age + 2'd1;
    end

    function automatic logic mask_ok(logic [DATA_W-1:0] v, logic [1:0] sz);
        int w;
        logic ok;
        w  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        ok = 1'b1;
        for (int i = 0; i < DATA_W; i++)
            if (v[i] != v[(i / w) * w]) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic usub_ok(logic [DATA_W-1:0] r, logic [DATA_W-1:0] d);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < NB; i++)
            if (r[i*8 +: 8] > d[i*8 +: 8]) ok = 1'b0;
        return ok;
    endfunction

    logic req_ill;
    always_comb req_ill = req_illegal(simd_op_e'(op), simd_pol_e'(mode), simd_size_e'(size));

    // R7
    latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2) |-> (res_valid == $past(in_valid, 2)));

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

    // R6
    cmp_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2 && res_valid && $past(in_valid, 2) && $past(op, 2) == 2'b10 && $past(size, 2) != 2'b11)
        |-> mask_ok(res, $past(size, 2)));

    // R5
    usub_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2 && res_valid && $past(in_valid, 2) && $past(op, 2) == 2'b01 &&
         $past(mode, 2) == 2'b10 && $past(size, 2) == 2'b00)
        |-> usub_ok(res, $past(dst, 2)));

    // R9, R10
    illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2 && res_valid && $past(in_valid, 2)) |-> (res_illegal == $past(req_ill, 2)));

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2 && res_valid && $past(in_valid, 2) && ($past(op, 2) == 2'b11 || $past(size, 2) == 2'b11))
        |-> (res == '0));
endmodule

bind simd_addsub_unit simd_addsub_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_simd_addsub_unit.sv
module sim_simd_addsub_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] dst = '0, src = '0;
    logic [1:0]  op = '0, mode = '0, size = '0;
    logic        res_valid;
    logic [63:0] res;
    logic        res_illegal;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    bit h1 = 1'b0, h2 = 1'b0;
    longint unsigned seed = 64'h9E3779B97F4A7C15;

    logic [63:0] q_res[$];
    logic        q_ill[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    simd_addsub_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst(dst), .src(src),
        .op(op), .mode(mode), .size(size),
        .res_valid(res_valid), .res(res), .res_illegal(res_illegal));

    function automatic logic [63:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 7;
        seed ^= seed << 17;
        return seed;
    endfunction

    // Reference: returns {illegal, result} from the requirement text.
    function automatic logic [64:0] model(logic [63:0] a, logic [63:0] b,
                                          logic [1:0] o, logic [1:0] m, logic [1:0] s);
        int w, nl;
        logic ill;
        logic [63:0] out;
        longint mask, half, ua, ub, sa, sb, us, ss, r;
        ill = (o == 2'b11) || (s == 2'b11) ||
              (o != 2'b10 && (m == 2'b11 || (s == 2'b10 && m != 2'b00)));
        if (o == 2'b11 || s == 2'b11) return {1'b1, 64'd0};
        w    = (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
        nl   = 64 / w;
        mask = (longint'(1) << w) - 1;
        half = longint'(1) << (w - 1);
        out  = '0;
        for (int i = 0; i < nl; i++) begin
            ua = longint'((a >> (i * w))) & mask;
            ub = longint'((b >> (i * w))) & mask;
            sa = (ua >= half) ? ua - (mask + 1) : ua;
            sb = (ub >= half) ? ub - (mask + 1) : ub;
            if (o == 2'b10) r = (ua == ub) ? mask : 0;
            else begin
                us = (o == 2'b00) ? ua + ub : ua - ub;
                ss = (o == 2'b00) ? sa + sb : sa - sb;
                if (!ill && m == 2'b01)
                    r = (ss > half - 1) ? half - 1 : (ss < -half) ? -half : ss;
                else if (!ill && m == 2'b10)
                    r = (us > mask) ? mask : (us < 0) ? 0 : us;
                else
                    r = us;
            end
            out |= (64'(r & mask)) << (i * w);
        end
        return {ill, out};
    endfunction

    function automatic string tag_of(logic [1:0] o, logic [1:0] m, logic [1:0] s);
        if (o == 2'b11 || s == 2'b11) return "R10";
        if (o == 2'b10) return "R6";
        if (m == 2'b11) return "R10";
        if (s == 2'b10 && m != 2'b00) return "R9";
        if (m == 2'b01) return "R3";
        if (m == 2'b10) return (o == 2'b00) ? "R4" : "R5";
        return (o == 2'b00) ? "R1" : "R2";
    endfunction

    task automatic issue(logic [63:0] a, logic [63:0] b, logic [1:0] o, logic [1:0] m, logic [1:0] s);
        logic [64:0] e;
        @(posedge clk); #1;
        in_valid = 1'b1; dst = a; src = b; op = o; mode = m; size = s;
        e = model(a, b, o, m, s);
        q_res.push_back(e[63:0]);
        q_ill.push_back(e[64]);
        q_tag.push_back(tag_of(o, m, s));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
        end
    endtask

    // Monitor: valid timing and result scoreboard, sampled at negedge.
    always @(negedge clk) begin
        if (!rst_n) begin
            q_res.delete(); q_ill.delete(); q_tag.delete();
            h1 = 1'b0; h2 = 1'b0;
        end else if (!done) begin
            checks++;
            if (res_valid !== h2) begin
                errors++;
                $display("FAIL R7 res_valid actual=%b expected=%b", res_valid, h2);
            end
            h2 = h1; h1 = in_valid;
            if (res_valid === 1'b1) begin
                checks++;
                if (q_res.size() == 0) begin
                    errors++;
                    $display("FAIL R7 unexpected result actual=%h expected=none", res);
                end else begin
                    logic [63:0] er; logic ei; string t;
                    er = q_res.pop_front(); ei = q_ill.pop_front(); t = q_tag.pop_front();
                    if (res !== er || res_illegal !== ei) begin
                        errors++;
                        $display("FAIL %s actual=%h/%b expected=%h/%b", t, res, res_illegal, er, ei);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [15:0] wc[8];
        logic [31:0] dc[6];
        wc = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF, 16'hFFFE, 16'h4000};
        dc = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'hC0000000};

        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8 res_valid in reset actual=%b expected=0", res_valid);
        end
        @(posedge clk); #1; rst_n = 1'b1;

        // R1-style sweep: every byte pair, adjacent lanes offset (R1 R2 R3 R4 R5)
        for (int o = 0; o < 2; o++)
            for (int m = 0; m < 3; m++)
                for (int x = 0; x < 256; x++)
                    for (int y = 0; y < 256; y += 8) begin
                        logic [63:0] a, b;
                        for (int i = 0; i < 8; i++) begin
                            a[i*8 +: 8] = 8'(x);
                            b[i*8 +: 8] = 8'(y + i);
                        end
                        issue(a, b, 2'(o), 2'(m), 2'b00);
                    end
        idle(3);

        // R6: compare on all sizes, mode varied and ignored
        for (int x = 0; x < 256; x++) begin
            logic [63:0] a, b;
            a = rnd();
            b = a;
            for (int i = 0; i < 8; i++)
                if (i >= x % 9) b[i*8 + (x % 8)] = ~b[i*8 + (x % 8)];
            issue(a, b, 2'b10, 2'(x % 4), 2'(x % 3));
        end

        // Word corners in rotated lane positions (R1 R2 R3 R4 R5 R6)
        for (int o = 0; o < 3; o++)
            for (int m = 0; m < 3; m++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        issue({wc[i], wc[j], wc[(i + 3) % 8], wc[(j + 5) % 8]},
                              {wc[j], wc[i], wc[(j + 1) % 8], wc[(i + 2) % 8]},
                              2'(o), 2'(m), 2'b01);

        // Random words and bytes, back to back (R7 throughput)
        for (int k = 0; k < 2000; k++)
            issue(rnd(), rnd(), 2'(k % 3), 2'((k / 3) % 3), 2'((k / 9) % 2));
        idle(2);

        // R9: doubleword corners under every policy
        for (int o = 0; o < 3; o++)
            for (int m = 0; m < 3; m++)
                for (int i = 0; i < 6; i++)
                    for (int j = 0; j < 6; j++)
                        issue({dc[i], dc[j]}, {dc[j], dc[(i + 1) % 6]}, 2'(o), 2'(m), 2'b10);

        // R10: reserved encodings
        for (int k = 0; k < 64; k++)
            issue(rnd(), rnd(), (k % 4 == 0) ? 2'b11 : 2'(k % 3),
                  2'((k / 4) % 4), ((k / 16) % 2 == 1) ? 2'b11 : 2'((k / 2) % 3));
        idle(4);

        // R8: reset with operations in flight; nothing emerges afterwards
        issue(64'h0123456789ABCDEF, 64'h1111111111111111, 2'b00, 2'b00, 2'b00);
        issue(64'hFFFFFFFFFFFFFFFF, 64'h1, 2'b01, 2'b10, 2'b01);
        @(posedge clk); #1; in_valid = 1'b0; rst_n = 1'b0;
        @(posedge clk); #1; rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            checks++;
            if (res_valid !== 1'b0) begin
                errors++;
                $display("FAIL R8 res_valid after flush actual=%b expected=0", res_valid);
            end
        end
        issue(64'h7F7F7F7F80808080, 64'h0101010101010101, 2'b00, 2'b01, 2'b00);
        idle(4);

        checks++;
        if (q_res.size() != 0) begin
            errors++;
            $display("FAIL R7 pending results actual=%0d expected=0", q_res.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule